// File: doc/BRIEF.md
# SMBus MCTP Packet Reassembler

This block is the receive side of a management endpoint that sits on an SMBus/I2C target. An I2C target front end hands it the bytes of each write transfer along with start and stop markers. The byte stream carries MCTP-style packets. No packet length is known in advance: each packet states its own length in an in-band count byte, and the block uses that count to find where the packet ends. A multi-packet message is built up by appending each packet's payload to a shared message buffer. The message is closed by the packet whose end-of-message flag is set.

When the message closes, the block pulses a completion strobe and publishes the total payload length. It also publishes the 7-bit address of the requester, so that the reply can be routed back to it. Firmware or a response engine then reads the payload through a synchronous read port. While a message is still being assembled, that port returns an all-ones busy byte instead of buffer data. PEC checking and bit-level I2C signalling belong to other blocks.

Stream positions count from 0. Position 0 is the first byte after a start condition, or the first byte after the previous packet ended.

Top module: `smbus_mctp_reasm`

## Requirements
- R1: The byte at position 1 is the count. A packet ends with the byte that brings the number of bytes received in it to count + 3. The next byte, with or without a new start condition, is position 0 of a new packet.
- R2: Payload bytes are those at position 8 and beyond. They are appended in arrival order at the running message offset, and `msg_len` equals the sum of the payload lengths of the message's packets. After completion, reading address a returns payload byte a.
- R3: Bit 6 of the byte at position 6 is the end-of-message flag. A completed packet with this bit clear adds its payload and leaves the message open, with no completion strobe.
- R4: `msg_done` is high for exactly one cycle. That cycle is the one following the clock edge that accepted the final byte of an end-of-message packet.
- R5: On completion, `reply_addr` takes bits 7:1 of the byte at position 2 of the final packet, and holds that value until the next completion.
- R6: `busy` rises after the first byte of a message is accepted and falls on completion. A read (`rd_en`) returns data one cycle later. While `busy` is high the data is 8'hFF; otherwise it is the buffered byte.
- R7: `msg_len` holds its value until a byte is accepted at position 6 with bit 7 (start-of-message) set. From that edge it reads 0, unless the same byte completes the message.
- R8: A stop condition before a packet has its count + 3 bytes discards that partial packet. Earlier packets of the message stay intact. If none of them added payload, `busy` falls.
- R9: A start condition during a partial packet discards it. The byte accepted together with that start is position 0 of a new packet.
- R10: A payload byte whose message offset is at or beyond BUF_DEPTH (5000) is not stored and sets `ovf_err`. `ovf_err` stays set until a start-of-message flag byte is accepted, and `msg_len` saturates at BUF_DEPTH.
- R11: A byte and a stop condition in the same cycle are handled with the byte first. If that byte completes a packet, the packet is committed normally.
- R12: A packet with count + 3 of 8 or less adds no payload. A packet too short to contain position 6 is treated as having its end-of-message flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | A received write byte is present this cycle |
| byte_data | input | 8 | Received write byte |
| xfer_start | input | 1 | Start or repeated-start condition seen |
| xfer_stop | input | 1 | Stop condition seen |
| rd_en | input | 1 | Read request for the message buffer |
| rd_addr | input | 13 | Message buffer byte address |
| rd_data | output | 8 | Read data, valid one cycle after rd_en |
| msg_done | output | 1 | One-cycle message completion strobe |
| msg_len | output | 13 | Payload length of the last completed message |
| reply_addr | output | 7 | Requester address for the reply |
| ovf_err | output | 1 | Sticky message buffer overflow |
| busy | output | 1 | Message assembly in progress |

## Verification
Two functions can fall in the same cycle. One is the acceptance of a packet's final byte together with a stop condition. The other is a start condition arriving together with the first byte of a new packet while an abandoned partial packet is still pending. The bench drives a message whose last byte carries the stop, and judges it by a normal completion strobe, length and readback. It also abandons a packet mid-payload and restarts with a start condition on the next packet's first byte, and judges that by the message length and buffer contents, which must exclude the abandoned bytes.

// File: rtl/smr_pkg.sv
// Shared types for the SMBus MCTP packet reassembler.
// Assumes at most 255 count-byte value, so a packet position fits in 9 bits.
package smr_pkg;

    localparam int POS_W = 9;

    // Per-byte event produced by the frame tracker for the message controller.
    typedef struct packed {
        logic       pay_vld;   // current byte is a payload byte
        logic [7:0] pay_idx;   // payload index within the packet
        logic       last;      // current byte completes the packet
        logic       eom;       // end-of-message flag of the packet
        logic [6:0] src;       // requester address of the packet
        logic       som;       // current byte is a flag byte with start-of-message
        logic       drop;      // partial packet discarded this cycle
    } smr_evt_t;

endpackage

// File: rtl/smr_frame_tracker.sv
// Tracks the position of each byte inside a packet, captures the count,
// address and flag bytes, and flags packet end, payload bytes and discards.
// Assumes start/stop markers are single-cycle pulses from the I2C front end.
module smr_frame_tracker
    import smr_pkg::*;
#(
    parameter int CNT_POS  = 1,
    parameter int SRC_POS  = 2,
    parameter int FLG_POS  = 6,
    parameter int PAY_OFS  = 8,
    parameter int OVERHEAD = 3,
    parameter int EOM_BIT  = 6,
    parameter int SOM_BIT  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    input  logic       xfer_start,
    input  logic       xfer_stop,
    output smr_evt_t   evt
);

    localparam logic [POS_W-1:0] P_CNT = POS_W'(CNT_POS);
    localparam logic [POS_W-1:0] P_SRC = POS_W'(SRC_POS);
    localparam logic [POS_W-1:0] P_FLG = POS_W'(FLG_POS);
    localparam logic [POS_W-1:0] P_PAY = POS_W'(PAY_OFS);
    localparam logic [POS_W-1:0] P_OVH = POS_W'(OVERHEAD);

    logic [POS_W-1:0] pos_q, eff_pos, nxt_pos;
    logic [7:0]       cnt_q;
    logic             eom_q;
    logic [6:0]       src_q;

    // Decode the current byte against the packet position.
    always_comb begin
        eff_pos     = xfer_start ? '0 : pos_q;
        nxt_pos     = eff_pos + 1'b1;
        evt.last    = byte_vld && (eff_pos > P_CNT) &&
                      (nxt_pos == ({1'b0, cnt_q} + P_OVH));
        evt.eom     = (eff_pos == P_FLG) ? byte_data[EOM_BIT] : eom_q;
        evt.src     = (eff_pos == P_SRC) ? byte_data[7:1] : src_q;
        evt.som     = byte_vld && (eff_pos == P_FLG) && byte_data[SOM_BIT];
        evt.pay_vld = byte_vld && (eff_pos >= P_PAY);
        evt.pay_idx = 8'(eff_pos - P_PAY);
        evt.drop    = (xfer_start && (pos_q != '0)) ||
                      (xfer_stop && !evt.last && (byte_vld || (eff_pos != '0)));
    end

    // Advance the position and capture header fields of the open packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            cnt_q <= '0;
            eom_q <= 1'b0;
            src_q <= '0;
        end else if (evt.last || xfer_stop) begin
            pos_q <= '0;
            cnt_q <= '0;
            eom_q <= 1'b0;
        end else if (byte_vld) begin
            pos_q <= nxt_pos;
            if (eff_pos == P_CNT) begin
                cnt_q <= byte_data;
            end else if (xfer_start) begin
                cnt_q <= '0;
            end
            if (eff_pos == P_FLG) begin
                eom_q <= byte_data[EOM_BIT];
            end else if (xfer_start) begin
                eom_q <= 1'b0;
            end
            if (eff_pos == P_SRC) begin
                src_q <= byte_data[7:1];
            end
        end else if (xfer_start) begin
            pos_q <= '0;
            cnt_q <= '0;
            eom_q <= 1'b0;
        end
    end

endmodule

// File: rtl/smr_msg_ctrl.sv
// Keeps the running message offset, commits packet payload at packet end,
// hands the message off on end-of-message and tracks overflow and busy.
// Assumes payload bytes of a packet are contiguous up to its last byte.
module smr_msg_ctrl
    import smr_pkg::*;
#(
    parameter int BUF_DEPTH = 5000,
    parameter int AW        = 13,
    parameter int LW        = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld,
    input  logic          xfer_stop,
    input  smr_evt_t      evt,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          msg_done,
    output logic [LW-1:0] msg_len,
    output logic [6:0]    reply_addr,
    output logic          ovf_err,
    output logic          busy
);

    localparam int SW = LW + 1;
    localparam logic [SW-1:0] DEPTH_S = SW'(BUF_DEPTH);

    logic [LW-1:0] off_q;
    logic [SW-1:0] wr_full, pkt_cnt, sum, sum_clamp;
    logic          in_rng, handoff, ovf_hit;

    // Address of the current payload byte and the committed sum at packet end.
    always_comb begin
        wr_full   = SW'(off_q) + SW'(evt.pay_idx);
        in_rng    = wr_full < DEPTH_S;
        wr_en     = evt.pay_vld && in_rng && !ovf_err;
        wr_addr   = AW'(wr_full);
        ovf_hit   = evt.pay_vld && !in_rng;
        pkt_cnt   = evt.pay_vld ? (SW'(evt.pay_idx) + SW'(1)) : '0;
        sum       = SW'(off_q) + pkt_cnt;
        sum_clamp = (sum > DEPTH_S) ? DEPTH_S : sum;
        handoff   = evt.last && evt.eom;
    end

    // Commit offsets, publish the finished message and keep sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q      <= '0;
            msg_done   <= 1'b0;
            msg_len    <= '0;
            reply_addr <= '0;
            ovf_err    <= 1'b0;
            busy       <= 1'b0;
        end else begin
            msg_done <= handoff;
            if (evt.som) begin
                msg_len <= '0;
                ovf_err <= 1'b0;
            end
            if (ovf_hit) begin
                ovf_err <= 1'b1;
            end
            if (handoff) begin
                off_q      <= '0;
                msg_len    <= LW'(sum_clamp);
                reply_addr <= evt.src;
                busy       <= 1'b0;
            end else if (evt.last) begin
                off_q <= LW'(sum_clamp);
                busy  <= 1'b1;
            end else if (evt.drop) begin
                busy <= (off_q != '0) || (byte_vld && !xfer_stop);
            end else if (byte_vld) begin
                busy <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/smr_msg_buf.sv
// Message byte store with a registered read port; reads return a filler
// value while a message is being assembled. Contents are not reset.
module smr_msg_buf #(
    parameter int         BUF_DEPTH = 5000,
    parameter int         AW        = 13,
    parameter logic [7:0] FILL      = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          busy,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [BUF_DEPTH];

    // Store accepted payload bytes.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read, substituting the filler while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= busy ? FILL : mem[rd_addr];
        end
    end

endmodule

// File: rtl/smbus_mctp_reasm.sv
// Top of the SMBus MCTP packet reassembler: frame tracking, message
// control and the message buffer. Assumes one received byte per cycle at most.
module smbus_mctp_reasm
    import smr_pkg::*;
#(
    parameter int         BUF_DEPTH = 5000,
    parameter int         CNT_POS   = 1,
    parameter int         SRC_POS   = 2,
    parameter int         FLG_POS   = 6,
    parameter int         PAY_OFS   = 8,
    parameter int         OVERHEAD  = 3,
    parameter int         EOM_BIT   = 6,
    parameter int         SOM_BIT   = 7,
    parameter logic [7:0] BUSY_FILL = 8'hFF,
    localparam int        AW        = $clog2(BUF_DEPTH),
    localparam int        LW        = $clog2(BUF_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld,
    input  logic [7:0]    byte_data,
    input  logic          xfer_start,
    input  logic          xfer_stop,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          msg_done,
    output logic [LW-1:0] msg_len,
    output logic [6:0]    reply_addr,
    output logic          ovf_err,
    output logic          busy
);

    smr_evt_t      evt;
    logic          wr_en;
    logic [AW-1:0] wr_addr;

    smr_frame_tracker #(
        .CNT_POS (CNT_POS),
        .SRC_POS (SRC_POS),
        .FLG_POS (FLG_POS),
        .PAY_OFS (PAY_OFS),
        .OVERHEAD(OVERHEAD),
        .EOM_BIT (EOM_BIT),
        .SOM_BIT (SOM_BIT)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .xfer_start(xfer_start),
        .xfer_stop (xfer_stop),
        .evt       (evt)
    );

    smr_msg_ctrl #(
        .BUF_DEPTH(BUF_DEPTH),
        .AW       (AW),
        .LW       (LW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .xfer_stop (xfer_stop),
        .evt       (evt),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .msg_done  (msg_done),
        .msg_len   (msg_len),
        .reply_addr(reply_addr),
        .ovf_err   (ovf_err),
        .busy      (busy)
    );

    smr_msg_buf #(
        .BUF_DEPTH(BUF_DEPTH),
        .AW       (AW),
        .FILL     (BUSY_FILL)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(byte_data),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .busy   (busy),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/smr_checker.sv
// Port-level properties of the reassembler, bound to every instance.
module smr_checker #(
    parameter int BUF_DEPTH = 5000,
    parameter int LW        = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          byte_vld,
    input logic          rd_en,
    input logic          msg_done,
    input logic [LW-1:0] msg_len,
    input logic          ovf_err,
    input logic          busy,
    input logic [7:0]    rd_data
);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |=> !msg_done);

    // R4
    done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |-> $past(byte_vld));

    // R6
    busy_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rd_data == 8'hFF));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |-> !busy);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && !byte_vld) |=> ovf_err);

    // R10
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_len <= LW'(BUF_DEPTH));

    // R7
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(msg_len));

endmodule

bind smbus_mctp_reasm smr_checker #(
    .BUF_DEPTH(BUF_DEPTH),
    .LW       (LW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_vld(byte_vld),
    .rd_en   (rd_en),
    .msg_done(msg_done),
    .msg_len (msg_len),
    .ovf_err (ovf_err),
    .busy    (busy),
    .rd_data (rd_data)
);

// File: tb/smbus_mctp_reasm_tb.sv
module smbus_mctp_reasm_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BUF_DEPTH  = 5000;
    localparam int AW         = 13;
    localparam int LW         = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          xfer_start = 1'b0;
    logic          xfer_stop = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          msg_done;
    logic [LW-1:0] msg_len;
    logic [6:0]    reply_addr;
    logic          ovf_err;
    logic          busy;

    logic [7:0] exp_mem [BUF_DEPTH];
    int exp_off = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    smbus_mctp_reasm u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .xfer_start(xfer_start),
        .xfer_stop (xfer_stop),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .msg_done  (msg_done),
        .msg_len   (msg_len),
        .reply_addr(reply_addr),
        .ovf_err   (ovf_err),
        .busy      (busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one byte for one clock; returns at the falling edge after it was taken.
    task automatic put(input logic [7:0] b, input bit st, input bit sp);
        byte_vld   = 1'b1;
        byte_data  = b;
        xfer_start = st;
        xfer_stop  = sp;
        @(negedge clk);
        byte_vld   = 1'b0;
        xfer_start = 1'b0;
        xfer_stop  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        rd_en   = 1'b1;
        rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    // Header byte for position p (count at 1, address at 2, flags at 6).
    function automatic logic [7:0] hdr(input int p, input int cnt,
                                       input logic [6:0] src, input bit som, input bit eom);
        case (p)
            0:       return 8'h1D;
            1:       return 8'(cnt);
            2:       return {src, 1'b1};
            6:       return {som, eom, 6'h01};
            default: return 8'(p * 17 + 3);
        endcase
    endfunction

    // Packet with plen payload bytes; optionally cut after byte 'cut', with stop on it.
    task automatic send_pkt(input logic [6:0] src, input bit som, input bit eom,
                            input int plen, input bit st, input int cut, input bit cut_stop);
        int total = plen + 8;
        bit commit = (cut < 0) || (cut == total - 1);
        for (int p = 0; p < total; p++) begin
            logic [7:0] b;
            if (p < 8) begin
                b = hdr(p, plen + 5, src, som, eom);
            end else begin
                b = 8'($urandom);
                if (commit && (exp_off + p - 8 < BUF_DEPTH)) exp_mem[exp_off + p - 8] = b;
            end
            put(b, st && (p == 0), cut_stop && (p == cut));
            if (p == cut) break;
        end
        if (commit) exp_off += plen;
    endtask

    // Called at the falling edge right after the final byte was accepted.
    task automatic verify_msg(input logic [6:0] src);
        int exp_len = (exp_off > BUF_DEPTH) ? BUF_DEPTH : exp_off;
        int bad = 0;
        logic [7:0] v;
        exp_off = 0;
        chk(msg_done == 1'b1, "R4", "msg_done after final byte", int'(msg_done), 1);
        chk(int'(msg_len) == exp_len, "R2", "msg_len", int'(msg_len), exp_len);
        chk(reply_addr == src, "R5", "reply_addr", int'(reply_addr), int'(src));
        chk(busy == 1'b0, "R6", "busy after completion", int'(busy), 0);
        @(negedge clk);
        chk(msg_done == 1'b0, "R4", "msg_done one cycle", int'(msg_done), 0);
        for (int a = 0; a < exp_len; a++) begin
            rd(a, v);
            if (v !== exp_mem[a]) begin
                if (bad == 0) $display("  first mismatch at %0d: %0d vs %0d", a, v, exp_mem[a]);
                bad++;
            end
        end
        chk(bad == 0, "R2", "readback mismatches", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk(msg_done == 0, "R4", "reset msg_done", int'(msg_done), 0);
        chk(busy == 0, "R6", "reset busy", int'(busy), 0);
        chk(ovf_err == 0, "R10", "reset ovf_err", int'(ovf_err), 0);
        chk(msg_len == 0, "R7", "reset msg_len", int'(msg_len), 0);
        chk(reply_addr == 0, "R5", "reset reply_addr", int'(reply_addr), 0);

        // R1 R2 R3: single-packet message
        send_pkt(7'h21, 1, 1, 4, 1, -1, 0);
        verify_msg(7'h21);

        // R3 R1: three packets, back to back without start conditions
        send_pkt(7'h30, 1, 0, 10, 1, -1, 0);
        chk(msg_done == 0, "R3", "no strobe without eom", int'(msg_done), 0);
        chk(busy == 1, "R3", "message open", int'(busy), 1);
        send_pkt(7'h30, 0, 0, 3, 0, -1, 0);
        send_pkt(7'h31, 0, 1, 7, 0, -1, 0);
        verify_msg(7'h31);

        // R1 R2: random messages
        for (int m = 0; m < 8; m++) begin
            int np = 1 + int'($urandom % 4);
            logic [6:0] src = 7'($urandom);
            for (int k = 0; k < np; k++) begin
                send_pkt(src, k == 0, k == np - 1, int'($urandom % 41),
                         (k == 0) || ($urandom % 2 == 1), -1, 0);
                if (k != np - 1) idle(int'($urandom % 3));
            end
            verify_msg(src);
        end

        // R12: packet of count 1 (too short for flags) leaves message open
        for (int p = 0; p < 4; p++) put(hdr(p, 1, 7'h44, 1, 1), p == 0, 0);
        chk(msg_done == 0, "R12", "short packet no strobe", int'(msg_done), 0);
        chk(busy == 1, "R12", "short packet keeps message open", int'(busy), 1);
        send_pkt(7'h45, 0, 1, 5, 0, -1, 0);
        verify_msg(7'h45);
        // R12: packet with no payload bytes
        send_pkt(7'h46, 1, 1, 0, 1, -1, 0);
        verify_msg(7'h46);

        // R7 R6: length held, then cleared by start-of-message flag byte
        send_pkt(7'h52, 1, 1, 6, 1, -1, 0);
        verify_msg(7'h52);
        idle(4);
        chk(msg_len == 6, "R7", "msg_len held while idle", int'(msg_len), 6);
        for (int p = 0; p < 6; p++) put(hdr(p, 7, 7'h53, 1, 1), p == 0, 0);
        chk(msg_len == 6, "R7", "msg_len before flag byte", int'(msg_len), 6);
        chk(busy == 1, "R6", "busy mid packet", int'(busy), 1);
        rd(0, v);
        chk(v == 8'hFF, "R6", "read while busy", int'(v), 255);
        put(hdr(6, 7, 7'h53, 1, 1), 0, 0);
        chk(msg_len == 0, "R7", "msg_len after som flag", int'(msg_len), 0);
        put(hdr(7, 7, 7'h53, 1, 1), 0, 0);
        for (int i = 0; i < 2; i++) begin
            logic [7:0] b = 8'($urandom);
            exp_mem[i] = b;
            put(b, 0, 0);
        end
        exp_off = 2;
        verify_msg(7'h53);

        // R8: stop mid packet keeps earlier packets
        send_pkt(7'h60, 1, 0, 5, 1, -1, 0);
        send_pkt(7'h60, 0, 0, 20, 0, 10, 1);
        chk(msg_done == 0, "R8", "no strobe on stop", int'(msg_done), 0);
        chk(busy == 1, "R8", "earlier payload keeps busy", int'(busy), 1);
        send_pkt(7'h61, 0, 1, 3, 1, -1, 0);
        verify_msg(7'h61);
        send_pkt(7'h62, 1, 1, 9, 1, 3, 1);
        chk(busy == 0, "R8", "lone partial packet dropped", int'(busy), 0);
        chk(msg_done == 0, "R8", "lone partial no strobe", int'(msg_done), 0);

        // R9: start condition restarts an abandoned packet
        send_pkt(7'h70, 1, 0, 4, 1, -1, 0);
        send_pkt(7'h70, 0, 0, 15, 0, 9, 0);
        send_pkt(7'h71, 0, 1, 6, 1, -1, 0);
        verify_msg(7'h71);

        // R11: stop in the same cycle as the final byte
        send_pkt(7'h78, 1, 1, 5, 1, 12, 1);
        verify_msg(7'h78);

        // R10: overflow past the buffer depth
        for (int k = 0; k < 21; k++) send_pkt(7'h7A, k == 0, k == 20, 250, k == 0, -1, 0);
        chk(ovf_err == 1, "R10", "ovf_err set", int'(ovf_err), 1);
        verify_msg(7'h7A);
        chk(ovf_err == 1, "R10", "ovf_err sticky", int'(ovf_err), 1);
        send_pkt(7'h7B, 1, 1, 3, 1, -1, 0);
        chk(ovf_err == 0, "R10", "ovf_err cleared by som", int'(ovf_err), 0);
        verify_msg(7'h7B);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule